// File: doc/BRIEF.md
# Timing Source Mode Control Arbiter

This block chooses the operating mode and the active reference input for a DPLL-based timing source. Three control sources compete for that choice. A master/slave pin has the final word. Next come four hardware select pins, which apply when a hardware-control pin is high. Last comes a control register that the host writes over a simple register port. Pins own the mode and reference fields whenever they are in charge. Host writes to those fields are then dropped, and reads return the values decoded from the pins.

After every reset the block is unconfigured, and it must receive a configuration image before it honours any control source. A source-select pin, sampled on the first clock after reset, picks where the image comes from. With the pin high, the block fetches the bytes from an external EEPROM through a request/valid handshake, and a timeout guards the fetch. With the pin low, the host writes the bytes over the register port and then writes a commit bit. The loader is a state machine with five states:
- `LD_SAMPLE` is the reset state. On the next clock it goes to `LD_EE_FETCH` or to `LD_BUS_WAIT`, depending on the source pin.
- `LD_EE_FETCH` goes to `LD_READY` when the last byte arrives, or to `LD_FAULT` after TIMEOUT cycles with no byte.
- `LD_BUS_WAIT` goes to `LD_READY` on a commit.
- `LD_READY` and `LD_FAULT` hold until reset.

Top module: `tsrc_mode_arbiter`

## Requirements
- R1: From reset until `cfg_done` is high, `mode_o` is 00 (free run), `ref_idx` is 0 and `ref_valid` is 0, whatever the pins or registers say. `cfg_done` and `cfg_err` are 0 after reset.
- R2: With `cfg_done` high and `pin_master` = 0 (slave), `mode_o` is 10 (locked) and `ref_idx` is 9 (the cross-couple reference). No register holds the master/slave choice.
- R3: In master mode with `pin_hw_ctl` = 1, `pin_sel[3:0]` is decoded as follows:
  - `pin_sel[3]` = 0 with `pin_sel[2:0]` from 000 to 110 gives holdover (01) with reference 0.
  - 0111 gives free run (00) with reference 0.
  - `pin_sel[3]` = 1 gives locked (10) with reference `pin_sel[2:0]`+1.
- R4: In master mode with `pin_hw_ctl` = 1, writes to the control register (address 0) leave its stored value unchanged. Reads of address 0 return {2'b0, decoded reference in bits 5:2, decoded mode in bits 1:0}.
- R5: In master mode with `pin_hw_ctl` = 0, the control register sets mode and reference. Bits 1:0 hold the mode and bits 5:2 the reference, and the fields map as follows:
  - mode 00 gives free run.
  - mode 01 gives holdover.
  - mode 10 with a reference from 1 to 8 gives locked with that reference.
  - mode 10 with any other reference gives holdover with reference 0.
  - mode 11 gives free run.
  - A read of address 0 returns the stored byte.
- R6: `ref_valid` is 1 exactly when `mode_o` is 10. Whenever `mode_o` is not 10, `ref_idx` is 0.
- R7: With `pin_cfg_src` = 1 at reset, the block raises `ee_req` and reads CFG_BYTES bytes, with `ee_addr` running 0, 1, and so on. Byte i lands in `cfg_image[8i+7:8i]`, and `cfg_done` rises after the last byte.
- R8: If no `ee_valid` arrives for TIMEOUT cycles while `ee_req` is high, `cfg_err` rises and `ee_req` drops. `cfg_done` stays 0 until the next reset.
- R9: With `pin_cfg_src` = 0 at reset, writes to address 2 store bytes into `cfg_image` in order. A write to address 3 with bit 0 set asserts `cfg_done`.
- R10: Writes to address 2 after `cfg_done` do not change `cfg_image`. Address 1 reads back the status byte: bit 0 `cfg_done`, bit 1 `cfg_err`, bit 2 `pin_master`, bit 3 `pin_hw_ctl`.
- R11: The mode and reference outputs are registered. A pin change shows at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sends the block to the unconfigured state |
| pin_master | input | 1 | 1 = master, 0 = slave |
| pin_hw_ctl | input | 1 | 1 = select pins own mode and reference |
| pin_sel | input | 4 | Hardware mode/reference select |
| pin_cfg_src | input | 1 | Configuration source: 1 EEPROM, 0 host bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| ee_req | output | 1 | EEPROM byte request, held while fetching |
| ee_addr | output | 2 | EEPROM byte address |
| ee_valid | input | 1 | EEPROM byte valid |
| ee_data | input | 8 | EEPROM byte |
| cfg_done | output | 1 | Configuration loaded |
| cfg_err | output | 1 | EEPROM fetch timed out |
| cfg_image | output | 32 | Loaded configuration bytes |
| mode_o | output | 2 | 00 free run, 01 holdover, 10 locked |
| ref_idx | output | 4 | 0 none, 1..8 reference, 9 cross-couple |
| ref_valid | output | 1 | Active reference is in use |

## Verification
On every cycle, the assertions check the following:
- the free-run hold before configuration;
- the slave override;
- the locked pin decode and the 0111 free-run decode;
- the pairing of `ref_valid` with the locked mode;
- that done and error never both show;
- that a stalled EEPROM never waits past the timeout.

Only the bench scenarios can show the rest. These are the register-field mapping, the dropped writes and the pin-derived readback, the byte order of both load paths, the frozen image after loading, and the single-cycle output latency.

// File: rtl/tsrc_mode_pkg.sv
package tsrc_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_HOLD = 2'b01,
        MODE_LOCK = 2'b10
    } tmode_e;

    localparam int          REF_W    = 4;
    localparam logic [3:0]  REF_NONE = 4'd0;
    localparam logic [3:0]  REF_XC   = 4'd9;
    localparam logic [3:0]  REF_MAX  = 4'd8;

    localparam logic [1:0]  RA_CTRL   = 2'd0;
    localparam logic [1:0]  RA_STAT   = 2'd1;
    localparam logic [1:0]  RA_CFG    = 2'd2;
    localparam logic [1:0]  RA_COMMIT = 2'd3;

    typedef enum logic [2:0] {
        LD_SAMPLE   = 3'd0,
        LD_EE_FETCH = 3'd1,
        LD_BUS_WAIT = 3'd2,
        LD_READY    = 3'd3,
        LD_FAULT    = 3'd4
    } ld_state_e;

    typedef struct packed {
        tmode_e           mode;
        logic [REF_W-1:0] ref_sel;
    } sel_t;

endpackage

// File: rtl/tsrc_sel_decode.sv
module tsrc_sel_decode
    import tsrc_mode_pkg::*;
(
    input  logic [3:0] sel,
    output sel_t       dec
);
    always_comb begin
        if (sel[3]) begin
            dec.mode    = MODE_LOCK;
            dec.ref_sel = {1'b0, sel[2:0]} + 4'd1;
        end else if (sel[2:0] == 3'b111) begin
            dec.mode    = MODE_FREE;
            dec.ref_sel = REF_NONE;
        end else begin
            dec.mode    = MODE_HOLD;
            dec.ref_sel = REF_NONE;
        end
    end
endmodule

// File: rtl/tsrc_ctrl_regs.sv
module tsrc_ctrl_regs
    import tsrc_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_owns,
    input  logic              cfg_done,
    input  logic              cfg_err,
    input  logic              pin_master,
    input  logic              pin_hw_ctl,
    input  sel_t              pin_dec,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output sel_t              reg_sel,
    output logic              byte_we,
    output logic              commit
);
    localparam int PAD_W = DATA_W - 6;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rd_mux;
    logic [1:0]        raw_mode;
    logic [3:0]        raw_ref;

    assign raw_mode = ctrl_q[1:0];
    assign raw_ref  = ctrl_q[5:2];
    assign byte_we  = wr && (addr == RA_CFG);
    assign commit   = wr && (addr == RA_COMMIT) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && addr == RA_CTRL && !hw_owns)
            ctrl_q <= wdata;
    end

    always_comb begin
        reg_sel.ref_sel = REF_NONE;
        unique case (raw_mode)
            2'b01: reg_sel.mode = MODE_HOLD;
            2'b10: begin
                if (raw_ref != REF_NONE && raw_ref <= REF_MAX) begin
                    reg_sel.mode    = MODE_LOCK;
                    reg_sel.ref_sel = raw_ref;
                end else begin
                    reg_sel.mode = MODE_HOLD;
                end
            end
            default: reg_sel.mode = MODE_FREE;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            RA_CTRL: rd_mux = hw_owns ? {{PAD_W{1'b0}}, pin_dec.ref_sel, pin_dec.mode} : ctrl_q;
            RA_STAT: rd_mux = {{(DATA_W-4){1'b0}}, pin_hw_ctl, pin_master, cfg_err, cfg_done};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd ? rd_mux : '0;
    end
endmodule

// File: rtl/tsrc_cfg_loader.sv
module tsrc_cfg_loader
    import tsrc_mode_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CFG_BYTES = 4,
    parameter int TIMEOUT   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        src_eeprom,
    input  logic                        ee_valid,
    input  logic [DATA_W-1:0]           ee_data,
    input  logic                        bus_byte_we,
    input  logic [DATA_W-1:0]           bus_byte,
    input  logic                        bus_commit,
    output logic                        ee_req,
    output logic [IDX_W-1:0]            ee_addr,
    output logic                        cfg_done,
    output logic                        cfg_err,
    output logic [CFG_BYTES*DATA_W-1:0] cfg_image
);
    localparam int IDX_W = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1;
    localparam int CNT_W = $clog2(CFG_BYTES + 1);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    ld_state_e         state, nxt;
    logic [CNT_W-1:0]  idx;
    logic [TMR_W-1:0]  timer;
    logic [DATA_W-1:0] img [CFG_BYTES];
    logic              last_byte;
    logic              expired;
    logic              take;
    logic [DATA_W-1:0] take_data;

    assign last_byte = (idx == CNT_W'(CFG_BYTES - 1));
    assign expired   = (timer == TMR_W'(TIMEOUT - 1));
    assign ee_addr   = idx[IDX_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_SAMPLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LD_SAMPLE:   nxt = src_eeprom ? LD_EE_FETCH : LD_BUS_WAIT;
            LD_EE_FETCH: begin
                if (ee_valid && last_byte)      nxt = LD_READY;
                else if (!ee_valid && expired)  nxt = LD_FAULT;
            end
            LD_BUS_WAIT: if (bus_commit) nxt = LD_READY;
            LD_READY:    nxt = LD_READY;
            LD_FAULT:    nxt = LD_FAULT;
            default:     nxt = LD_SAMPLE;
        endcase
    end

    // registered outputs, aligned with the state they describe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_req   <= 1'b0;
            cfg_done <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            ee_req   <= (nxt == LD_EE_FETCH);
            cfg_done <= (nxt == LD_READY);
            cfg_err  <= (nxt == LD_FAULT);
        end
    end

    always_comb begin
        take      = 1'b0;
        take_data = ee_data;
        if (state == LD_EE_FETCH && ee_valid) begin
            take = 1'b1;
        end else if (state == LD_BUS_WAIT && bus_byte_we && idx < CNT_W'(CFG_BYTES)) begin
            take      = 1'b1;
            take_data = bus_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            timer <= '0;
            for (int i = 0; i < CFG_BYTES; i++) img[i] <= '0;
        end else begin
            if (take) begin
                img[idx[IDX_W-1:0]] <= take_data;
                idx                 <= idx + 1'b1;
            end
            if (state == LD_EE_FETCH && !ee_valid) timer <= timer + 1'b1;
            else                                   timer <= '0;
        end
    end

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_image
        assign cfg_image[g*DATA_W +: DATA_W] = img[g];
    end
endmodule

// File: rtl/tsrc_mode_arbiter.sv
module tsrc_mode_arbiter
    import tsrc_mode_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CFG_BYTES = 4,
    parameter int TIMEOUT   = 16,
    parameter int EE_AW     = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pin_master,
    input  logic                        pin_hw_ctl,
    input  logic [3:0]                  pin_sel,
    input  logic                        pin_cfg_src,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [1:0]                  reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic                        ee_req,
    output logic [EE_AW-1:0]            ee_addr,
    input  logic                        ee_valid,
    input  logic [DATA_W-1:0]           ee_data,
    output logic                        cfg_done,
    output logic                        cfg_err,
    output logic [CFG_BYTES*DATA_W-1:0] cfg_image,
    output logic [1:0]                  mode_o,
    output logic [REF_W-1:0]            ref_idx,
    output logic                        ref_valid
);
    sel_t pin_dec;
    sel_t reg_sel;
    sel_t eff;
    logic hw_owns;
    logic byte_we;
    logic commit;

    assign hw_owns = pin_master && pin_hw_ctl;

    tsrc_sel_decode u_dec (
        .sel (pin_sel),
        .dec (pin_dec)
    );

    tsrc_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_owns    (hw_owns),
        .cfg_done   (cfg_done),
        .cfg_err    (cfg_err),
        .pin_master (pin_master),
        .pin_hw_ctl (pin_hw_ctl),
        .pin_dec    (pin_dec),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .reg_sel    (reg_sel),
        .byte_we    (byte_we),
        .commit     (commit)
    );

    tsrc_cfg_loader #(
        .DATA_W    (DATA_W),
        .CFG_BYTES (CFG_BYTES),
        .TIMEOUT   (TIMEOUT)
    ) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_eeprom  (pin_cfg_src),
        .ee_valid    (ee_valid),
        .ee_data     (ee_data),
        .bus_byte_we (byte_we),
        .bus_byte    (reg_wdata),
        .bus_commit  (commit),
        .ee_req      (ee_req),
        .ee_addr     (ee_addr),
        .cfg_done    (cfg_done),
        .cfg_err     (cfg_err),
        .cfg_image   (cfg_image)
    );

    // precedence: unconfigured, then slave, then pins, then register
    always_comb begin
        if (!cfg_done) begin
            eff.mode    = MODE_FREE;
            eff.ref_sel = REF_NONE;
        end else if (!pin_master) begin
            eff.mode    = MODE_LOCK;
            eff.ref_sel = REF_XC;
        end else if (pin_hw_ctl) begin
            eff = pin_dec;
        end else begin
            eff = reg_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o    <= MODE_FREE;
            ref_idx   <= REF_NONE;
            ref_valid <= 1'b0;
        end else begin
            mode_o    <= eff.mode;
            ref_idx   <= eff.ref_sel;
            ref_valid <= (eff.mode == MODE_LOCK);
        end
    end
endmodule

// File: rtl/tsrc_mode_arbiter_chk.sv
module tsrc_mode_arbiter_chk #(
    parameter int TIMEOUT = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_master,
    input logic       pin_hw_ctl,
    input logic [3:0] pin_sel,
    input logic       cfg_done,
    input logic       cfg_err,
    input logic       ee_req,
    input logic       ee_valid,
    input logic [1:0] mode_o,
    input logic [3:0] ref_idx,
    input logic       ref_valid
);
    localparam int SC_W = $clog2(TIMEOUT + 2);
    logic [SC_W-1:0] stall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stall_cnt <= '0;
        else if (ee_req && !ee_valid) begin
            if (stall_cnt != SC_W'(TIMEOUT + 1)) stall_cnt <= stall_cnt + 1'b1;
        end else
            stall_cnt <= '0;
    end

    AST_UNCONFIGURED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> (mode_o == 2'b00 && ref_idx == 4'd0 && !ref_valid)); // R1
    AST_SLAVE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && !pin_master) |=> (mode_o == 2'b10 && ref_idx == 4'd9)); // R2
    AST_PIN_LOCKED_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && pin_master && pin_hw_ctl && pin_sel[3])
        |=> (mode_o == 2'b10 && ref_idx == ({1'b0, $past(pin_sel[2:0])} + 4'd1))); // R3
    AST_PIN_FREE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && pin_master && pin_hw_ctl && pin_sel == 4'b0111)
        |=> (mode_o == 2'b00 && ref_idx == 4'd0)); // R3
    AST_VALID_MATCHES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid == (mode_o == 2'b10)); // R6
    AST_NO_REF_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b10) |-> (ref_idx == 4'd0)); // R6
    AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_done && cfg_err)); // R8
    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        stall_cnt <= SC_W'(TIMEOUT)); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done); // R7
endmodule

bind tsrc_mode_arbiter tsrc_mode_arbiter_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_master (pin_master),
    .pin_hw_ctl (pin_hw_ctl),
    .pin_sel    (pin_sel),
    .cfg_done   (cfg_done),
    .cfg_err    (cfg_err),
    .ee_req     (ee_req),
    .ee_valid   (ee_valid),
    .mode_o     (mode_o),
    .ref_idx    (ref_idx),
    .ref_valid  (ref_valid)
);

// File: tb/tsrc_mode_arbiter_tb.sv
module tsrc_mode_arbiter_tb;
    localparam int TIMEOUT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_master = 1'b1, pin_hw_ctl = 1'b0, pin_cfg_src = 1'b0;
    logic [3:0]  pin_sel = 4'h0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        ee_req, ee_valid = 1'b0, ee_en = 1'b1;
    logic [1:0]  ee_addr;
    logic [7:0]  ee_data = 8'h00;
    logic        cfg_done, cfg_err, ref_valid;
    logic [31:0] cfg_image;
    logic [1:0]  mode_o;
    logic [3:0]  ref_idx;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    tsrc_mode_arbiter #(.TIMEOUT(TIMEOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_master(pin_master), .pin_hw_ctl(pin_hw_ctl),
        .pin_sel(pin_sel), .pin_cfg_src(pin_cfg_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ee_req(ee_req), .ee_addr(ee_addr), .ee_valid(ee_valid), .ee_data(ee_data),
        .cfg_done(cfg_done), .cfg_err(cfg_err), .cfg_image(cfg_image),
        .mode_o(mode_o), .ref_idx(ref_idx), .ref_valid(ref_valid)
    );

    // EEPROM model: one byte every other cycle while requested
    initial begin
        forever begin
            @(negedge clk);
            ee_valid = ee_en && ee_req && !ee_valid;
            ee_data  = 8'hA0 + 8'h11 * {6'b0, ee_addr};
        end
    end

    // {master, hw, sel[3:0], mode[1:0], ref[3:0]}
    localparam logic [11:0] VEC [18] = '{
        12'b1_1_0000_01_0000, 12'b1_1_0001_01_0000, 12'b1_1_0010_01_0000,
        12'b1_1_0011_01_0000, 12'b1_1_0100_01_0000, 12'b1_1_0101_01_0000,
        12'b1_1_0110_01_0000, 12'b1_1_0111_00_0000, 12'b1_1_1000_10_0001,
        12'b1_1_1001_10_0010, 12'b1_1_1010_10_0011, 12'b1_1_1011_10_0100,
        12'b1_1_1100_10_0101, 12'b1_1_1101_10_0110, 12'b1_1_1110_10_0111,
        12'b1_1_1111_10_1000, 12'b0_1_0111_10_1001, 12'b1_0_1111_00_0000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [1:0] m, input logic [3:0] r);
        chk(req, {25'd0, mode_o, ref_idx, ref_valid}, {25'd0, m, r, (m == 2'b10)});
    endtask

    task automatic do_reset(input logic src);
        @(negedge clk);
        pin_cfg_src = src;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_pins(input logic m, input logic h, input logic [3:0] s);
        pin_master = m; pin_hw_ctl = h; pin_sel = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;

        // ---- bus-mode load; slave pins must not leak before done (R1)
        pin_master = 1'b0; pin_hw_ctl = 1'b1; pin_sel = 4'b1000;
        do_reset(1'b0);
        repeat (4) @(negedge clk);
        chk("R1 reset outputs", {27'd0, mode_o, ref_idx, ref_valid}, 32'd0);
        chk("R1 flags after reset", {30'd0, cfg_done, cfg_err}, 32'd0);
        bus_wr(2'd2, 8'h11); bus_wr(2'd2, 8'h22); bus_wr(2'd2, 8'h33); bus_wr(2'd2, 8'h44);
        chk_out("R1 still free run before commit", 2'b00, 4'd0);
        bus_wr(2'd3, 8'h01);
        @(negedge clk);
        chk("R9 cfg_done on commit", {31'd0, cfg_done}, 32'd1);
        chk("R9 image byte order", cfg_image, 32'h44332211);
        chk_out("R2 slave forces cross-couple", 2'b10, 4'd9);
        bus_wr(2'd2, 8'h55);
        @(negedge clk);
        chk("R10 image frozen after done", cfg_image, 32'h44332211);

        // ---- pin decode table (R3, R2, R6)
        for (int i = 0; i < 18; i++) begin
            set_pins(VEC[i][11], VEC[i][10], VEC[i][9:6]);
            chk_out($sformatf("R3 vector %0d", i), VEC[i][5:4], VEC[i][3:0]);
        end

        // ---- register control (R5)
        set_pins(1'b1, 1'b0, 4'b0000);
        bus_wr(2'd0, 8'h16); @(negedge clk);
        chk_out("R5 locked ref 5", 2'b10, 4'd5);
        bus_wr(2'd0, 8'h01); @(negedge clk);
        chk_out("R5 holdover", 2'b01, 4'd0);
        bus_wr(2'd0, 8'h03); @(negedge clk);
        chk_out("R5 code 11 free run", 2'b00, 4'd0);
        bus_wr(2'd0, 8'h02); @(negedge clk);
        chk_out("R5 locked ref 0 gives holdover", 2'b01, 4'd0);
        bus_wr(2'd0, 8'h26); @(negedge clk);
        chk_out("R5 locked ref 9 gives holdover", 2'b01, 4'd0);
        bus_wr(2'd0, 8'h22); @(negedge clk);
        chk_out("R5 locked ref 8", 2'b10, 4'd8);
        bus_rd(2'd0, rd);
        chk("R5 ctrl readback", {24'd0, rd}, 32'h22);

        // ---- pins own the fields (R4)
        set_pins(1'b1, 1'b1, 4'b1010);
        bus_wr(2'd0, 8'h01); @(negedge clk);
        chk_out("R4 pins win over write", 2'b10, 4'd3);
        bus_rd(2'd0, rd);
        chk("R4 read returns pin fields", {24'd0, rd}, 32'h0E);
        set_pins(1'b1, 1'b0, 4'b1010);
        chk_out("R4 dropped write left register", 2'b10, 4'd8);
        bus_rd(2'd0, rd);
        chk("R4 stored byte unchanged", {24'd0, rd}, 32'h22);
        bus_rd(2'd1, rd);
        chk("R10 status byte", {24'd0, rd}, 32'h05);
        set_pins(1'b0, 1'b0, 4'b1010);
        chk_out("R2 slave beats register", 2'b10, 4'd9);

        // ---- latency (R11)
        set_pins(1'b1, 1'b1, 4'b1111);
        pin_sel = 4'b0111;
        #1;
        chk_out("R11 no change before edge", 2'b10, 4'd8);
        @(negedge clk);
        chk_out("R11 change after one edge", 2'b00, 4'd0);

        // ---- EEPROM load (R7)
        pin_master = 1'b1; pin_hw_ctl = 1'b1; pin_sel = 4'b1000; ee_en = 1'b1;
        do_reset(1'b1);
        @(negedge clk);
        chk("R7 ee_req raised", {31'd0, ee_req}, 32'd1);
        for (int i = 0; i < 100 && !cfg_done; i++) @(negedge clk);
        chk("R7 cfg_done after fetch", {31'd0, cfg_done}, 32'd1);
        chk("R7 image from EEPROM", cfg_image, 32'hD3C2B1A0);
        chk("R7 ee_req dropped", {31'd0, ee_req}, 32'd0);
        @(negedge clk);
        chk_out("R7 pins active after load", 2'b10, 4'd1);
        bus_rd(2'd1, rd);
        chk("R10 status after EEPROM load", {24'd0, rd}, 32'h0D);

        // ---- EEPROM timeout (R8)
        ee_en = 1'b0;
        do_reset(1'b1);
        repeat (TIMEOUT + 10) @(negedge clk);
        chk("R8 error flag and no done", {30'd0, cfg_done, cfg_err}, 32'd1);
        chk("R8 ee_req released", {31'd0, ee_req}, 32'd0);
        chk_out("R8 held free run", 2'b00, 4'd0);
        bus_rd(2'd1, rd);
        chk("R10 status after timeout", {24'd0, rd}, 32'h0E);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule